// File: doc/BRIEF.md
# Multichannel ADC Acquisition Sequencer

This block runs the conversion sequence for a 64-way analog input front end that shares one track-and-hold stage and one 12-bit converter. A start command selects a channel and holds off for a programmable settling delay. It then drives the track-and-hold through a programmable tracking interval. When tracking ends it switches the stage to hold and pulses a convert command to the converter. The converter is modelled by a start/busy/data handshake: the sequencer waits for busy to rise and then fall, and captures the 12-bit result.

Two operating styles exist. In random poll mode a single chosen channel is converted and its result is kept in a random data register with a new-data flag. In scanning mode every channel from 0 up to a programmed last channel is converted in turn, each with its own full settle and track phases. Each result lands in a per-channel result buffer, and a latched end-of-scan flag marks the finish. A small synchronous register port gives access to the control/status word, the random data register, the two interval registers and the result buffer. Read data appears one cycle after the read strobe.

Register map (reg_addr, 7 bits): top bit 0 selects a control register by the low bits (0 control/status, 1 random data, 2 settle count, 3 track count). Top bit 1 selects result buffer entry reg_addr[5:0]. Control/status on write: bit 0 start, bit 1 scan mode, bits [13:8] channel (random) or last channel (scan). Control/status on read: bit 0 busy, bit 1 scan mode, bit 2 converting, bit 3 new data, bit 4 end of scan, bits [13:8] channel field.

Top module: `adc_acq_seq`

## Requirements
- R1: After reset the control/status word reads 0, th_track and adc_start are 0, and the settle and track registers (addresses 2 and 3) read 4 and 2.
- R2: After an accepted start, th_track stays low for exactly the settle count in cycles and then rises.
- R3: th_track stays high for exactly the track count in cycles. adc_start is then a one-cycle pulse in the next cycle, with chan_sel holding the channel being converted.
- R4: Control/status bit 2 (converting) is 1 from the convert pulse until the result is captured, and 0 at all other times.
- R5: In random mode the captured result is readable at address 1 (bits [11:0]) and sets control/status bit 3 (new data). A random conversion never sets bit 4.
- R6: A read of address 1 clears control/status bit 3, and bit 2 then reads 0.
- R7: In scanning mode channels 0 through the last channel are converted in ascending order, each with its own settle and track phases. Each result is stored at buffer address 64 plus the channel, and entries that were not scanned keep 0.
- R8: Finishing the last channel of a scan sets control/status bit 4. That bit is cleared by a control/status read, which still returns the set value, and by the start of a new scan.
- R9: A control/status write while busy (bit 0 = 1) is ignored entirely: no extra conversion starts, and the mode and channel fields keep their values.
- R10: Writing 0 to the settle or track register stores 1. That register then reads back 1 and times a one-cycle phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after reg_rd |
| chan_sel | output | 6 | Input channel selected for the analog path |
| th_track | output | 1 | 1 = track-and-hold tracking, 0 = holding |
| adc_start | output | 1 | One-cycle convert command |
| adc_busy | input | 1 | Converter busy |
| adc_data | input | 12 | Converter result, valid when busy falls |

## Verification
Counting from the clock edge that takes the start write, th_track rises after exactly the settle count of cycles. It stays high for the track count, and adc_start follows in the next cycle. The result is captured on the first edge that sees adc_busy low after it was high, so flags and data change one edge later. Register reads return on the edge after the strobe. The bench drives and samples on falling edges and counts falling edges between events, so each phase length is compared as a cycle count. Register values are taken only after the read edge. A scoreboard queue holds the channel expected at every convert pulse, so a missing, extra or misordered conversion is caught at the moment it occurs.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_SETTLE,
    SEQ_TRACK,
    SEQ_CONV_WAIT,
    SEQ_CONV_RUN
  } seq_state_e;

  // register indices inside the control region
  localparam int REG_CSR    = 0;
  localparam int REG_RAND   = 1;
  localparam int REG_SETTLE = 2;
  localparam int REG_TRACK  = 3;

  // control/status bit positions
  localparam int CSR_START    = 0;
  localparam int CSR_BUSY     = 0;
  localparam int CSR_SCAN     = 1;
  localparam int CSR_CONV     = 2;
  localparam int CSR_NEWDATA  = 3;
  localparam int CSR_EOS      = 4;
  localparam int CSR_CHAN_LSB = 8;

endpackage

// File: rtl/acq_interval_timer.sv
module acq_interval_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  // last cycle of the loaded interval
  assign expire = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/acq_seq_fsm.sv
module acq_seq_fsm
  import adc_acq_pkg::*;
#(
  parameter int CH_W  = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_scan,
  input  logic [CH_W-1:0]  go_chan,
  input  logic [CNT_W-1:0] settle_cyc,
  input  logic [CNT_W-1:0] track_cyc,
  input  logic             tmr_expire,
  input  logic             adc_busy,
  output seq_state_e       state,
  output logic [CH_W-1:0]  chan,
  output logic             scan_act,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             adc_start,
  output logic             th_track,
  output logic             cap_evt,
  output logic             scan_end_evt
);

  seq_state_e      state_nx;
  logic [CH_W-1:0] last_q;
  logic            more_w;

  function automatic logic more_to_scan(input logic [CH_W-1:0] cur,
                                        input logic [CH_W-1:0] last);
    return cur != last;
  endfunction

  assign more_w = scan_act && more_to_scan(chan, last_q);

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = settle_cyc;
    cap_evt  = 1'b0;
    unique case (state)
      SEQ_IDLE: if (go) begin
        state_nx = SEQ_SETTLE;
        tmr_load = 1'b1;
      end
      SEQ_SETTLE: if (tmr_expire) begin
        state_nx = SEQ_TRACK;
        tmr_load = 1'b1;
        tmr_val  = track_cyc;
      end
      SEQ_TRACK: if (tmr_expire) state_nx = SEQ_CONV_WAIT;
      SEQ_CONV_WAIT: if (adc_busy) state_nx = SEQ_CONV_RUN;
      SEQ_CONV_RUN: if (!adc_busy) begin
        cap_evt = 1'b1;
        if (more_w) begin
          state_nx = SEQ_SETTLE;
          tmr_load = 1'b1;
        end else begin
          state_nx = SEQ_IDLE;
        end
      end
      default: state_nx = SEQ_IDLE;
    endcase
  end

  assign scan_end_evt = cap_evt && scan_act && !more_to_scan(chan, last_q);
  assign th_track     = (state == SEQ_TRACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      chan      <= '0;
      last_q    <= '0;
      scan_act  <= 1'b0;
      adc_start <= 1'b0;
    end else begin
      state     <= state_nx;
      adc_start <= (state == SEQ_TRACK) && tmr_expire;
      if (go && state == SEQ_IDLE) begin
        scan_act <= go_scan;
        last_q   <= go_chan;
        chan     <= go_scan ? '0 : go_chan;
      end else if (cap_evt && more_w) begin
        chan <= chan + 1'b1;
      end
    end
  end

endmodule

// File: rtl/acq_result_buf.sv
module acq_result_buf #(
  parameter int CH_W   = 6,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CH_W-1:0]   rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << CH_W;

  logic [DATA_W-1:0] entry_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                               q <= '0;
      else if (wr_en && wr_idx == CH_W'(g))     q <= wr_data;
    end
    assign entry_w[g] = q;
  end

  assign rd_data = entry_w[rd_idx];

endmodule

// File: rtl/adc_acq_seq.sv
module adc_acq_seq
  import adc_acq_pkg::*;
#(
  parameter int CH_W       = 6,
  parameter int DATA_W     = 12,
  parameter int CNT_W      = 8,
  parameter int REG_W      = 16,
  parameter int SETTLE_RST = 4,
  parameter int TRACK_RST  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [CH_W:0]     reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [CH_W-1:0]   chan_sel,
  output logic              th_track,
  output logic              adc_start,
  input  logic              adc_busy,
  input  logic [DATA_W-1:0] adc_data
);

  function automatic logic [CNT_W-1:0] min_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  function automatic logic ctl_hit(input logic [CH_W:0] a, input int idx);
    return !a[CH_W] && (a[CH_W-1:0] == CH_W'(idx));
  endfunction

  seq_state_e        state;
  logic              scan_act, tmr_load, tmr_expire, cap_evt, scan_end_evt;
  logic [CNT_W-1:0]  tmr_val;
  logic [CNT_W-1:0]  settle_r, track_r;
  logic              mode_r;
  logic [CH_W-1:0]   chan_cfg_r;
  logic [DATA_W-1:0] rand_data_r, buf_rd;
  logic              new_data_r, eos_r;
  logic [REG_W-1:0]  rd_mux;

  // named events for the checker
  logic busy_w, conv_w, settle_w, csr_wr, start_wr, go_w, csr_rd, rand_rd;

  assign busy_w   = (state != SEQ_IDLE);
  assign conv_w   = (state == SEQ_CONV_WAIT) || (state == SEQ_CONV_RUN);
  assign settle_w = (state == SEQ_SETTLE);
  assign csr_wr   = reg_wr && ctl_hit(reg_addr, REG_CSR);
  assign start_wr = csr_wr && reg_wdata[CSR_START];
  assign go_w     = start_wr && !busy_w;
  assign csr_rd   = reg_rd && ctl_hit(reg_addr, REG_CSR);
  assign rand_rd  = reg_rd && ctl_hit(reg_addr, REG_RAND);

  acq_interval_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (tmr_expire)
  );

  acq_seq_fsm #(.CH_W(CH_W), .CNT_W(CNT_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (go_w),
    .go_scan      (reg_wdata[CSR_SCAN]),
    .go_chan      (reg_wdata[CSR_CHAN_LSB +: CH_W]),
    .settle_cyc   (settle_r),
    .track_cyc    (track_r),
    .tmr_expire   (tmr_expire),
    .adc_busy     (adc_busy),
    .state        (state),
    .chan         (chan_sel),
    .scan_act     (scan_act),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .adc_start    (adc_start),
    .th_track     (th_track),
    .cap_evt      (cap_evt),
    .scan_end_evt (scan_end_evt)
  );

  acq_result_buf #(.CH_W(CH_W), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cap_evt && scan_act),
    .wr_idx  (chan_sel),
    .wr_data (adc_data),
    .rd_idx  (reg_addr[CH_W-1:0]),
    .rd_data (buf_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      settle_r    <= min_one(CNT_W'(SETTLE_RST));
      track_r     <= min_one(CNT_W'(TRACK_RST));
      mode_r      <= 1'b0;
      chan_cfg_r  <= '0;
      rand_data_r <= '0;
      new_data_r  <= 1'b0;
      eos_r       <= 1'b0;
    end else begin
      if (reg_wr && ctl_hit(reg_addr, REG_SETTLE))
        settle_r <= min_one(reg_wdata[CNT_W-1:0]);
      if (reg_wr && ctl_hit(reg_addr, REG_TRACK))
        track_r <= min_one(reg_wdata[CNT_W-1:0]);
      if (csr_wr && !busy_w) begin
        mode_r     <= reg_wdata[CSR_SCAN];
        chan_cfg_r <= reg_wdata[CSR_CHAN_LSB +: CH_W];
      end
      if (cap_evt && !scan_act) begin
        rand_data_r <= adc_data;
        new_data_r  <= 1'b1;
      end else if (rand_rd) begin
        new_data_r <= 1'b0;
      end
      if (scan_end_evt)                                 eos_r <= 1'b1;
      else if (csr_rd || (go_w && reg_wdata[CSR_SCAN])) eos_r <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr[CH_W]) begin
      rd_mux[DATA_W-1:0] = buf_rd;
    end else if (ctl_hit(reg_addr, REG_CSR)) begin
      rd_mux[CSR_BUSY]                  = busy_w;
      rd_mux[CSR_SCAN]                  = mode_r;
      rd_mux[CSR_CONV]                  = conv_w;
      rd_mux[CSR_NEWDATA]               = new_data_r;
      rd_mux[CSR_EOS]                   = eos_r;
      rd_mux[CSR_CHAN_LSB +: CH_W]      = chan_cfg_r;
    end else if (ctl_hit(reg_addr, REG_RAND)) begin
      rd_mux[DATA_W-1:0] = rand_data_r;
    end else if (ctl_hit(reg_addr, REG_SETTLE)) begin
      rd_mux[CNT_W-1:0] = settle_r;
    end else if (ctl_hit(reg_addr, REG_TRACK)) begin
      rd_mux[CNT_W-1:0] = track_r;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/adc_acq_seq_chk.sv
module adc_acq_seq_chk #(
  parameter int CH_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            adc_start,
  input logic            adc_busy,
  input logic            th_track,
  input logic [CH_W-1:0] chan_sel,
  input logic            conv_w,
  input logic            busy_w,
  input logic            settle_w,
  input logic            new_data_r,
  input logic            eos_r,
  input logic            cap_evt,
  input logic            scan_act,
  input logic            scan_end_evt,
  input logic            rand_rd,
  input logic            start_wr
);

  // R2
  settle_before_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(th_track) |-> $past(settle_w));

  // R3
  start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  // R3
  start_after_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> $past(th_track));

  // R4
  conv_flag_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> conv_w);

  // R5
  new_data_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(new_data_r) |-> $past(cap_evt && !scan_act));

  // R6
  rand_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rand_rd && !cap_evt) |=> !new_data_r);

  // R8
  eos_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eos_r) |-> $past(scan_end_evt));

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && busy_w && !cap_evt) |=> $stable(chan_sel));

endmodule

bind adc_acq_seq adc_acq_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .adc_start    (adc_start),
  .adc_busy     (adc_busy),
  .th_track     (th_track),
  .chan_sel     (chan_sel),
  .conv_w       (conv_w),
  .busy_w       (busy_w),
  .settle_w     (settle_w),
  .new_data_r   (new_data_r),
  .eos_r        (eos_r),
  .cap_evt      (cap_evt),
  .scan_act     (scan_act),
  .scan_end_evt (scan_end_evt),
  .rand_rd      (rand_rd),
  .start_wr     (start_wr)
);

// File: tb/adc_acq_seq_tb.sv
module adc_acq_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [5:0]  chan_sel;
  logic        th_track;
  logic        adc_start;
  logic        adc_busy = 1'b0;
  logic [11:0] adc_data = '0;

  int n_chk = 0;
  int n_fail = 0;
  int data_base = 0;
  int exp_ch[$];
  bit done = 0;

  always #10 clk = ~clk;

  adc_acq_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .chan_sel(chan_sel), .th_track(th_track), .adc_start(adc_start),
    .adc_busy(adc_busy), .adc_data(adc_data)
  );

  function automatic int exp_data(input int ch);
    return (ch * 53 + data_base) % 4096;
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 7'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 7'(a);
    @(negedge clk);
    v = int'(reg_rdata);
    reg_rd = 1'b0;
  endtask

  // called on the falling edge right after the start write
  task automatic measure(output int s, output int t);
    s = 0; t = 0;
    while (!th_track && s < 1000) begin s++; @(negedge clk); end
    while (th_track && t < 1000) begin t++; @(negedge clk); end
  endtask

  task automatic quiet();
    repeat (60) @(negedge clk);
  endtask

  // converter model
  initial begin
    forever begin
      @(negedge clk);
      if (adc_start) begin
        adc_busy = 1'b1;
        repeat (3) @(negedge clk);
        adc_data = 12'(exp_data(int'(chan_sel)));
        adc_busy = 1'b0;
      end
    end
  end

  // scoreboard monitor: each convert pulse must match the next queued channel
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && adc_start) begin
        if (exp_ch.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R9 unexpected conversion actual=%0d expected=none", chan_sel);
        end else begin
          chk("R3/R7 channel at convert pulse", int'(chan_sel), exp_ch.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int v, s, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 th_track", int'(th_track), 0);
    chk("R1 adc_start", int'(adc_start), 0);
    rd(0, v); chk("R1 status word", v, 0);
    rd(2, v); chk("R1 settle default", v, 4);
    rd(3, v); chk("R1 track default", v, 2);

    // random conversion of channel 5
    wr(2, 3); wr(3, 2);
    data_base = 100;
    exp_ch.push_back(5);
    wr(0, (5 << 8) | 1);
    measure(s, t);
    chk("R2 settle cycles", s, 3);
    chk("R3 track cycles", t, 2);
    chk("R3 convert pulse", int'(adc_start), 1);
    chk("R3 channel held", int'(chan_sel), 5);
    @(negedge clk);
    chk("R3 pulse one cycle", int'(adc_start), 0);
    rd(0, v);
    chk("R4 converting bit during conversion", (v >> 2) & 1, 1);
    quiet();
    rd(0, v);
    chk("R4 converting bit after capture", (v >> 2) & 1, 0);
    chk("R5 new data bit", (v >> 3) & 1, 1);
    chk("R5 no end of scan in random mode", (v >> 4) & 1, 0);
    rd(1, v); chk("R5 random data", v, exp_data(5));
    rd(0, v);
    chk("R6 new data cleared by read", (v >> 3) & 1, 0);
    chk("R6 converting bit low", (v >> 2) & 1, 0);

    // R9 start while busy is ignored
    data_base = 2000;
    exp_ch.push_back(7);
    wr(0, (7 << 8) | 1);
    wr(0, (9 << 8) | 3);
    rd(0, v);
    chk("R9 busy bit", v & 1, 1);
    chk("R9 mode kept", (v >> 1) & 1, 0);
    chk("R9 channel kept", (v >> 8) & 63, 7);
    quiet();
    rd(1, v); chk("R9 single conversion result", v, exp_data(7));
    chk("R9 no queued conversions left", exp_ch.size(), 0);

    // R7/R8 scan of channels 0..3
    wr(2, 2); wr(3, 1);
    data_base = 900;
    for (int c = 0; c < 4; c++) exp_ch.push_back(c);
    wr(0, (3 << 8) | 3);
    measure(s, t);
    chk("R7 scan settle cycles", s, 2);
    chk("R7 scan track cycles", t, 1);
    repeat (2) quiet();
    rd(0, v);
    chk("R8 end of scan set", (v >> 4) & 1, 1);
    chk("R7 idle after scan", v & 1, 0);
    chk("R5 scan does not set new data", (v >> 3) & 1, 0);
    rd(0, v);
    chk("R8 end of scan cleared by read", (v >> 4) & 1, 0);
    for (int c = 0; c < 4; c++) begin
      rd(64 + c, v); chk("R7 buffer entry", v, exp_data(c));
    end
    rd(64 + 4, v); chk("R7 unscanned entry", v, 0);
    chk("R7 all scan channels converted", exp_ch.size(), 0);

    // R8 end of scan cleared by a new scan start
    data_base = 40;
    exp_ch.push_back(0);
    wr(0, (0 << 8) | 3);
    quiet();
    exp_ch.push_back(0); exp_ch.push_back(1);
    wr(0, (1 << 8) | 3);
    rd(0, v);
    chk("R8 cleared by new scan", (v >> 4) & 1, 0);
    repeat (2) quiet();
    rd(0, v);
    chk("R8 set after second scan", (v >> 4) & 1, 1);
    rd(64 + 1, v); chk("R7 buffer after rescan", v, exp_data(1));

    // R10 zero intervals become one cycle
    wr(2, 0); wr(3, 0);
    rd(2, v); chk("R10 settle reads 1", v, 1);
    rd(3, v); chk("R10 track reads 1", v, 1);
    data_base = 7;
    exp_ch.push_back(63);
    wr(0, (63 << 8) | 1);
    measure(s, t);
    chk("R10 settle one cycle", s, 1);
    chk("R10 track one cycle", t, 1);
    quiet();
    rd(1, v); chk("R10 random data ch63", v, exp_data(63));
    chk("R3 scoreboard drained", exp_ch.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule